// File: doc/BRIEF.md
# Temperature Limit Compare and Alert Controller

This block sits between the converter that produces local and remote temperature readings and the serial-bus slave logic of a temperature monitor. Each time a channel presents a new reading with its valid strobe, the block compares that signed reading with the channel's high and low limits. A trip sets a sticky alarm flag. A remote-sensor fault (an open diode or a diode shorted to a rail) forces the remote reading to the top of the scale and sets a fault flag. The flags drive an active-low alert line unless the alert mask is set.

The bus logic reports two kinds of event to the block. The first is a read of the whole status byte, which clears every flag. The second is a receive-byte transfer to the alert response address, 7'b0001100. While the alert is asserted, the block answers that transfer with its own slave address. It then keeps only those flags whose condition is still present in the latest reading. While the alert is not asserted it answers with a NACK. If another responder wins arbitration, the bus logic flags that with the lost-arbitration input; the block then does not ACK and leaves the alert as it was.

Top module: `limit_alert_ctrl`

## Requirements
- R1: On a cycle with `loc_vld_i` high, the local high flag (status bit 6) is set when the signed reading is greater than `loc_hi_i`, and the local low flag (status bit 5) is set when it is less than `loc_lo_i`. A reading equal to a limit trips nothing.
- R2: The same rule applies to the remote channel on `rem_vld_i`, using `rem_hi_i` and `rem_lo_i`. It sets the remote high flag (bit 4) and the remote low flag (bit 3).
- R3: Comparisons take place only on a valid strobe. Changing a temperature or a limit without a strobe does not change the status.
- R4: `status_o` is {busy_i, local high, local low, remote high, remote low, fault, 2'b00}. Flags stay set until `stat_rd_i` clears all of them in one cycle. A flag that is set in the same cycle as the clear is kept.
- R5: `alert_no` is low exactly when at least one flag is set and `cfg_mask_i` is 0. The mask gates only the pin and never the flags.
- R6: On `rem_vld_i` with `rem_fault_i` high, `rem_temp_o` becomes 127 and the fault flag (bit 2) is set. The remote limits are evaluated against 127.
- R7: When `ara_req_i` arrives while `alert_no` is low and `ara_lost_i` is low, the block pulses `ara_ack_o` one cycle later, with `ara_data_o` = {own_addr_i, 1'b0}. Each flag is kept only if the condition of its channel's latest reading still holds; every other flag is cleared.
- R8: When `ara_req_i` arrives while `alert_no` is high, including when flags are set but masked, the block pulses `ara_nack_o` one cycle later and leaves the flags unchanged.
- R9: When `ara_req_i` arrives with `ara_lost_i` high, the block pulses `ara_nack_o` and not `ara_ack_o`. The flags and the alert stay unchanged.
- R10: After reset, all flags are clear, `alert_no` is high, both readings are 0 and neither response pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| loc_temp_i | input | TW | Local reading, two's complement |
| loc_vld_i | input | 1 | Local reading valid strobe |
| rem_temp_i | input | TW | Remote reading, two's complement |
| rem_vld_i | input | 1 | Remote reading valid strobe |
| rem_fault_i | input | 1 | Remote diode open or shorted, sampled with rem_vld_i |
| loc_hi_i | input | TW | Local high limit |
| loc_lo_i | input | TW | Local low limit |
| rem_hi_i | input | TW | Remote high limit |
| rem_lo_i | input | TW | Remote low limit |
| cfg_mask_i | input | 1 | Alert mask (configuration bit 7) |
| busy_i | input | 1 | Converter busy, shown in status bit 7 |
| stat_rd_i | input | 1 | Status byte read strobe |
| own_addr_i | input | 7 | Own slave address |
| ara_req_i | input | 1 | Receive-byte to alert response address |
| ara_lost_i | input | 1 | Arbitration lost during the response |
| loc_temp_o | output | TW | Latched local reading |
| rem_temp_o | output | TW | Latched remote reading, forced on fault |
| status_o | output | 8 | Status byte |
| alert_no | output | 1 | Active-low alert |
| ara_ack_o | output | 1 | Alert response acknowledged |
| ara_nack_o | output | 1 | Alert response not acknowledged |
| ara_data_o | output | 8 | Alert response byte |

## Verification
The bench builds the block with the default TW = 8, so it can sweep every one of the 256 signed readings on each channel against several limit pairs, including limits of -128, -1 and 127. Within that range the comparisons at the signed wrap and at equality are all reached. The remote sweep puts a fault on a regular subset of the readings, which tests the forcing to 127 against the same limits. Targeted sequences then cover the sticky flags, the mask, and the three outcomes of an alert response.

// File: rtl/limit_alert_pkg.sv
package limit_alert_pkg;
  localparam int ADDR_W = 7;
  localparam int NFLAG  = 5;
  // flag vector order matches status bits 6..2
  localparam int F_LHI  = 4;
  localparam int F_LLO  = 3;
  localparam int F_RHI  = 2;
  localparam int F_RLO  = 1;
  localparam int F_FLT  = 0;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/temp_limit_cmp.sv
module temp_limit_cmp #(
  parameter int TW        = 8,
  parameter bit HAS_FAULT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [TW-1:0] temp_i,
  input  logic          fault_i,
  input  logic [TW-1:0] hi_i,
  input  logic [TW-1:0] lo_i,
  output logic          hi_set_o,
  output logic          lo_set_o,
  output logic          flt_set_o,
  output logic          hi_cond_o,
  output logic          lo_cond_o,
  output logic          flt_cond_o,
  output logic [TW-1:0] temp_o
);
  localparam logic [TW-1:0] TMAX = {1'b0, {(TW-1){1'b1}}};

  logic [TW-1:0] eff;
  logic          flt;

  generate
    if (HAS_FAULT) begin : g_fault
      assign flt = fault_i;
      assign eff = fault_i ? TMAX : temp_i;
    end else begin : g_plain
      logic unused_fault;
      assign unused_fault = fault_i;
      assign flt = 1'b0;
      assign eff = temp_i;
    end
  endgenerate

  logic hi_trip, lo_trip;
  assign hi_trip = $signed(eff) > $signed(hi_i);
  assign lo_trip = $signed(eff) < $signed(lo_i);

  assign hi_set_o  = vld_i & hi_trip;
  assign lo_set_o  = vld_i & lo_trip;
  assign flt_set_o = vld_i & flt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_o     <= '0;
      hi_cond_o  <= 1'b0;
      lo_cond_o  <= 1'b0;
      flt_cond_o <= 1'b0;
    end else if (vld_i) begin
      temp_o     <= eff;
      hi_cond_o  <= hi_trip;
      lo_cond_o  <= lo_trip;
      flt_cond_o <= flt;
    end
  end
endmodule

// File: rtl/alert_flag_reg.sv
module alert_flag_reg import limit_alert_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t set_i,
  input  flag_vec_t cond_i,
  input  logic      stat_clr_i,
  input  logic      ara_clr_i,
  input  logic      mask_i,
  output flag_vec_t flags_o,
  output logic      alert_no
);
  flag_vec_t flags_d;

  always_comb begin
    flags_d = flags_o;
    if (stat_clr_i)     flags_d = '0;
    else if (ara_clr_i) flags_d = flags_o & cond_i;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= flags_d;
  end

  assign alert_no = ~((|flags_o) & ~mask_i);
endmodule

// File: rtl/alert_resp_unit.sv
module alert_resp_unit import limit_alert_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              lost_i,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              clr_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic [7:0]        data_o
);
  assign clr_o = req_i & active_i & ~lost_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o  <= 1'b0;
      nack_o <= 1'b0;
      data_o <= '0;
    end else begin
      ack_o  <= clr_o;
      nack_o <= req_i & ~clr_o;
      if (clr_o) data_o <= {addr_i, 1'b0};
    end
  end
endmodule

// File: rtl/limit_alert_ctrl.sv
module limit_alert_ctrl import limit_alert_pkg::*; #(
  parameter int TW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TW-1:0]     loc_temp_i,
  input  logic              loc_vld_i,
  input  logic [TW-1:0]     rem_temp_i,
  input  logic              rem_vld_i,
  input  logic              rem_fault_i,
  input  logic [TW-1:0]     loc_hi_i,
  input  logic [TW-1:0]     loc_lo_i,
  input  logic [TW-1:0]     rem_hi_i,
  input  logic [TW-1:0]     rem_lo_i,
  input  logic              cfg_mask_i,
  input  logic              busy_i,
  input  logic              stat_rd_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ara_req_i,
  input  logic              ara_lost_i,
  output logic [TW-1:0]     loc_temp_o,
  output logic [TW-1:0]     rem_temp_o,
  output logic [7:0]        status_o,
  output logic              alert_no,
  output logic              ara_ack_o,
  output logic              ara_nack_o,
  output logic [7:0]        ara_data_o
);
  logic l_hi_s, l_lo_s, l_f_s, l_hi_c, l_lo_c, l_f_c;
  logic r_hi_s, r_lo_s, r_f_s, r_hi_c, r_lo_c, r_f_c;
  flag_vec_t set_v, cond_v, flags;
  logic ara_clr;

  temp_limit_cmp #(.TW(TW), .HAS_FAULT(1'b0)) u_loc (
    .clk_i, .rst_ni, .vld_i(loc_vld_i), .temp_i(loc_temp_i), .fault_i(1'b0),
    .hi_i(loc_hi_i), .lo_i(loc_lo_i),
    .hi_set_o(l_hi_s), .lo_set_o(l_lo_s), .flt_set_o(l_f_s),
    .hi_cond_o(l_hi_c), .lo_cond_o(l_lo_c), .flt_cond_o(l_f_c),
    .temp_o(loc_temp_o)
  );

  temp_limit_cmp #(.TW(TW), .HAS_FAULT(1'b1)) u_rem (
    .clk_i, .rst_ni, .vld_i(rem_vld_i), .temp_i(rem_temp_i), .fault_i(rem_fault_i),
    .hi_i(rem_hi_i), .lo_i(rem_lo_i),
    .hi_set_o(r_hi_s), .lo_set_o(r_lo_s), .flt_set_o(r_f_s),
    .hi_cond_o(r_hi_c), .lo_cond_o(r_lo_c), .flt_cond_o(r_f_c),
    .temp_o(rem_temp_o)
  );

  always_comb begin
    set_v         = '0;
    cond_v        = '0;
    set_v[F_LHI]  = l_hi_s;  cond_v[F_LHI] = l_hi_c;
    set_v[F_LLO]  = l_lo_s;  cond_v[F_LLO] = l_lo_c;
    set_v[F_RHI]  = r_hi_s;  cond_v[F_RHI] = r_hi_c;
    set_v[F_RLO]  = r_lo_s;  cond_v[F_RLO] = r_lo_c;
    set_v[F_FLT]  = r_f_s | l_f_s;
    cond_v[F_FLT] = r_f_c | l_f_c;
  end

  alert_flag_reg u_flags (
    .clk_i, .rst_ni, .set_i(set_v), .cond_i(cond_v),
    .stat_clr_i(stat_rd_i), .ara_clr_i(ara_clr), .mask_i(cfg_mask_i),
    .flags_o(flags), .alert_no(alert_no)
  );

  alert_resp_unit u_ara (
    .clk_i, .rst_ni, .req_i(ara_req_i), .lost_i(ara_lost_i),
    .active_i(~alert_no), .addr_i(own_addr_i), .clr_o(ara_clr),
    .ack_o(ara_ack_o), .nack_o(ara_nack_o), .data_o(ara_data_o)
  );

  assign status_o = {busy_i, flags, 2'b00};
endmodule

// File: rtl/limit_alert_ctrl_chk.sv
module limit_alert_ctrl_chk import limit_alert_pkg::*; #(
  parameter int TW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TW-1:0]     loc_temp_i,
  input logic              loc_vld_i,
  input logic [TW-1:0]     rem_temp_i,
  input logic              rem_vld_i,
  input logic              rem_fault_i,
  input logic              cfg_mask_i,
  input logic              stat_rd_i,
  input logic              ara_req_i,
  input logic              ara_lost_i,
  input logic [TW-1:0]     rem_temp_o,
  input logic [7:0]        status_o,
  input logic              alert_no,
  input logic              ara_ack_o,
  input logic              ara_nack_o
);
  localparam logic [TW-1:0] TMAX = {1'b0, {(TW-1){1'b1}}};

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_rd_i && !ara_req_i) |=>
      ((status_o[6:2] & $past(status_o[6:2])) == $past(status_o[6:2])));

  p_stat_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !loc_vld_i && !rem_vld_i) |=> (status_o[6:2] == '0));

  p_mask_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mask_i |-> alert_no);

  p_fault_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_vld_i && rem_fault_i) |=> (rem_temp_o == TMAX && status_o[2]));

  p_idle_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_req_i && alert_no) |=> (ara_nack_o && !ara_ack_o));

  p_lost_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_req_i && ara_lost_i && !stat_rd_i && !cfg_mask_i) |=> (ara_nack_o && !ara_ack_o && ($past(alert_no) == alert_no || !alert_no)));

  p_resp_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ara_ack_o && ara_nack_o));
endmodule

bind limit_alert_ctrl limit_alert_ctrl_chk #(.TW(TW)) u_chk (
  .clk_i, .rst_ni, .loc_temp_i, .loc_vld_i, .rem_temp_i, .rem_vld_i, .rem_fault_i,
  .cfg_mask_i, .stat_rd_i, .ara_req_i, .ara_lost_i, .rem_temp_o, .status_o,
  .alert_no, .ara_ack_o, .ara_nack_o
);

// File: tb/limit_alert_ctrl_bench.sv
module limit_alert_ctrl_bench;
  localparam int TW = 8;
  logic clk_i = 0, rst_ni = 0;
  logic [TW-1:0] loc_temp_i = 0, rem_temp_i = 0;
  logic loc_vld_i = 0, rem_vld_i = 0, rem_fault_i = 0;
  logic [TW-1:0] loc_hi_i = 8'd127, loc_lo_i = 8'h80, rem_hi_i = 8'd127, rem_lo_i = 8'h80;
  logic cfg_mask_i = 0, busy_i = 0, stat_rd_i = 0, ara_req_i = 0, ara_lost_i = 0;
  logic [6:0] own_addr_i = 7'b1001101;
  logic [TW-1:0] loc_temp_o, rem_temp_o;
  logic [7:0] status_o, ara_data_o;
  logic alert_no, ara_ack_o, ara_nack_o;
  int tests = 0, fails = 0, cyc = 0;

  always #5 clk_i = ~clk_i;

  limit_alert_ctrl #(.TW(TW)) u_limit_alert_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic clear_status();
    stat_rd_i = 1; step(); stat_rd_i = 0;
  endtask

  task automatic ara(input logic lost);
    ara_req_i = 1; ara_lost_i = lost; step(); ara_req_i = 0; ara_lost_i = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk_i); cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int lim_hi [3] = '{25, -1, 127};
    int lim_lo [3] = '{-10, -1, -128};
    @(negedge clk_i); step();
    // R10 reset state
    chk("R10 status", status_o, 0);
    chk("R10 alert", alert_no, 1);
    chk("R10 resp", {ara_ack_o, ara_nack_o}, 0);
    chk("R10 rem", rem_temp_o, 0);
    rst_ni = 1; step();
    busy_i = 1; #1 chk("R4 busy bit", status_o, 8'h80); busy_i = 0;

    // R1 local sweep
    for (int k = 0; k < 3; k++) begin
      loc_hi_i = lim_hi[k][7:0]; loc_lo_i = lim_lo[k][7:0];
      for (int t = -128; t < 128; t++) begin
        loc_temp_i = t[7:0]; loc_vld_i = 1; step(); loc_vld_i = 0;
        chk("R1 local flags", status_o[6:5], {t > lim_hi[k], t < lim_lo[k]});
        chk("R1 alert", alert_no, !((t > lim_hi[k]) || (t < lim_lo[k])));
        clear_status();
      end
    end

    // R2/R6 remote sweep with faults
    for (int k = 0; k < 3; k++) begin
      rem_hi_i = lim_hi[k][7:0]; rem_lo_i = lim_lo[k][7:0];
      for (int t = -128; t < 128; t++) begin
        int e;
        logic f;
        f = (t % 7) == 0;
        e = f ? 127 : t;
        rem_temp_i = t[7:0]; rem_fault_i = f; rem_vld_i = 1; step();
        rem_vld_i = 0; rem_fault_i = 0;
        chk("R2 remote flags", status_o[4:2], {e > lim_hi[k], e < lim_lo[k], f});
        chk("R6 remote reading", rem_temp_o, e[7:0]);
        clear_status();
      end
    end
    chk("R4 cleared", status_o, 0);

    // R3 no compare without strobe
    loc_hi_i = 8'd10; loc_lo_i = 8'hF6; loc_temp_i = 8'd50; step();
    rem_lo_i = 8'd100; step();
    chk("R3 no strobe", status_o, 0);
    chk("R3 alert idle", alert_no, 1);

    // R4 set wins over same-cycle clear; sticky
    loc_vld_i = 1; stat_rd_i = 1; step(); loc_vld_i = 0; stat_rd_i = 0;
    chk("R4 set wins", status_o, 8'h40);
    loc_temp_i = 8'd0; loc_vld_i = 1; step(); loc_vld_i = 0;
    chk("R4 sticky", status_o, 8'h40);

    // R5/R8 mask gates pin only; masked alert NACKs
    cfg_mask_i = 1; #1 chk("R5 masked pin", alert_no, 1);
    ara(0);
    chk("R8 masked nack", {ara_ack_o, ara_nack_o}, 2'b01);
    chk("R8 flags kept", status_o, 8'h40);
    cfg_mask_i = 0; #1 chk("R5 unmasked pin", alert_no, 0);

    // R9 lost arbitration
    ara(1);
    chk("R9 nack", {ara_ack_o, ara_nack_o}, 2'b01);
    chk("R9 alert held", alert_no, 0);
    chk("R9 flags", status_o, 8'h40);

    // R7 condition persists: flag kept
    loc_temp_i = 8'd50; loc_vld_i = 1; step(); loc_vld_i = 0;
    ara(0);
    chk("R7 ack", {ara_ack_o, ara_nack_o}, 2'b10);
    chk("R7 data", ara_data_o, {own_addr_i, 1'b0});
    chk("R7 persist", status_o, 8'h40);
    chk("R7 alert still", alert_no, 0);
    // condition gone: flag clears
    loc_temp_i = 8'd0; loc_vld_i = 1; step(); loc_vld_i = 0;
    ara(0);
    chk("R7 ack2", ara_ack_o, 1);
    chk("R7 cleared", status_o, 0);
    chk("R7 released", alert_no, 1);
    ara(0);
    chk("R8 idle nack", {ara_ack_o, ara_nack_o}, 2'b01);
    step();
    chk("R7 pulse ends", {ara_ack_o, ara_nack_o}, 0);

    // R6 persisting fault re-asserts after response
    rem_hi_i = 8'd127; rem_lo_i = 8'h80;
    rem_fault_i = 1; rem_vld_i = 1; step(); rem_vld_i = 0; rem_fault_i = 0;
    ara(0);
    chk("R6 fault persists", status_o, 8'h04);
    chk("R6 alert", alert_no, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule